// File: doc/BRIEF.md
# H-Bridge Protection Fault Supervisor

This block is the digital supervisor for a motor H-bridge. It receives comparator outputs that are already digital: a flag for current-sense over threshold, one overcurrent flag for each bridge FET, a die over-temperature trip flag, a separate flag that marks the cooled-down release point, and a supply undervoltage flag. From these inputs it decides whether the bridge may switch. It also asks the PWM stage to reduce duty when the sensed current stays too high, holds the internal logic in reset during undervoltage, and reports faults to the host on an active-low line.

Each class of fault recovers in its own way:

- **Current limiting:** the block reports a sustained current limit as a fault, but the bridge keeps running, and the fault clears by itself.
- **FET overcurrent:** an overcurrent that survives its filter time shuts the bridge down and stays latched.
- **Over-temperature:** the shutdown holds until the release flag says the die has cooled below the hysteresis point.
- **Undervoltage:** the block clears every timer and latch and blocks the bridge while the supply is low.

Every filter and persistence time is given as a physical time plus the clock frequency. The block converts these to cycle counts when it is elaborated.

Top module: `hb_fault_supervisor`

## Requirements
- R1: After reset, with all flags low, `bridge_en`=1, `fault_n`=1, `ilim_req`=0 and `logic_rst`=0.
- R2: A current-sense over-threshold pulse that lasts fewer than LIM_FILT cycles (the filter time converted to clock cycles) never raises `ilim_req`.
- R3: When the current-sense flag stays high for LIM_FILT cycles, `ilim_req` rises two synchroniser cycles plus LIM_FILT cycles after the flag rises. It stays high for as long as the flag is held.
- R4: When `ilim_req` stays high for LIM_FAULT cycles without a break, `fault_n` goes low and `bridge_en` stays 1.
- R5: The current-limit fault and `ilim_req` clear three cycles after the sense flag falls, with no host action. If `ilim_req` drops before the persistence count completes, that count starts again from zero.
- R6: A FET overcurrent pulse that lasts fewer than OCP_FILT cycles has no effect on any output.
- R7: When any FET overcurrent flag stays high for OCP_FILT cycles, `bridge_en` and `fault_n` go low. Both stay low after the flag clears.
- R8: The overcurrent shutdown is released only by `rst_n` or by undervoltage. Thermal trip and release activity leaves it latched.
- R9: Over-temperature trip drives `bridge_en` and `fault_n` low. They return high only after the release flag is seen while the trip flag is low. The release flag has no effect while the trip flag is high.
- R10: Undervoltage drives `logic_rst` high and drives `bridge_en`, `fault_n` and `ilim_req` low. It clears all timers and latches, so the current filter and the persistence count both restart once the supply returns.
- R11: With the current-sense flag held low, `ilim_req` never rises and no current-limit fault appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| isense_hi | input | 1 | Current-sense voltage above limit reference |
| fet_oc | input | N_FET | Per-FET overcurrent comparator flags |
| ot_trip | input | 1 | Die temperature above shutdown threshold |
| ot_release | input | 1 | Die temperature below threshold minus hysteresis |
| uv_flag | input | 1 | Supply below undervoltage threshold |
| bridge_en | output | 1 | Bridge may switch |
| ilim_req | output | 1 | Request to PWM stage to cut duty |
| fault_n | output | 1 | Active-low fault report to host |
| logic_rst | output | 1 | Internal-logic reset during undervoltage |

## Verification
The hardest state to reach from the ports is a persistence count that has really been restarted rather than simply carried on. To reach it, the stimulus first lets the current limit run part of the way toward a fault. It then breaks the limit either with a one-cycle drop of the sense flag or with an undervoltage pulse, and checks that the fault appears exactly one full persistence window after the current limit re-engages. The bench checks the overcurrent latch in a similar way: after the flag has cleared, it drives thermal trip and release activity to show that only undervoltage frees the latch.

// File: rtl/hbs_pkg.sv
package hbs_pkg;

  // Convert a duration in nanoseconds to clock cycles, never below one.
  function automatic longint unsigned ns_to_cycles(longint unsigned clk_khz,
                                                   longint unsigned dur_ns);
    longint unsigned c;
    c = (clk_khz * dur_ns) / 64'd1000000;
    if (c == 0) c = 1;
    return c;
  endfunction

  // Convert a duration in microseconds to clock cycles, never below one.
  function automatic longint unsigned us_to_cycles(longint unsigned clk_khz,
                                                   longint unsigned dur_us);
    longint unsigned c;
    c = (clk_khz * dur_us) / 64'd1000;
    if (c == 0) c = 1;
    return c;
  endfunction

endpackage

// File: rtl/hbs_sync.sv
module hbs_sync #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= async_in;
      stab_q <= meta_q;
    end
  end

  assign sync_out = stab_q;

endmodule

// File: rtl/hbs_persist.sv
// Counts consecutive cycles of a high level; done once LIMIT cycles are seen.
module hbs_persist #(
  parameter longint unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic level,
  output logic done
);

  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (clr || !level) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (cnt_q != LIM) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done = (cnt_q == LIM);

endmodule

// File: rtl/hb_fault_supervisor.sv
module hb_fault_supervisor
  import hbs_pkg::*;
#(
  parameter int unsigned N_FET        = 4,
  parameter int unsigned CLK_KHZ      = 200000,
  parameter int unsigned LIM_FILT_NS  = 3000,
  parameter int unsigned LIM_FAULT_US = 275000,
  parameter int unsigned OCP_FILT_NS  = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             isense_hi,
  input  logic [N_FET-1:0] fet_oc,
  input  logic             ot_trip,
  input  logic             ot_release,
  input  logic             uv_flag,
  output logic             bridge_en,
  output logic             ilim_req,
  output logic             fault_n,
  output logic             logic_rst
);

  localparam int unsigned     FLAG_W        = N_FET + 4;
  localparam longint unsigned LIM_FILT_CYC  = ns_to_cycles(CLK_KHZ, LIM_FILT_NS);
  localparam longint unsigned LIM_FAULT_CYC = us_to_cycles(CLK_KHZ, LIM_FAULT_US);
  localparam longint unsigned OCP_FILT_CYC  = ns_to_cycles(CLK_KHZ, OCP_FILT_NS);

  // Synchronised flags.
  logic [FLAG_W-1:0] raw_flags;
  logic [FLAG_W-1:0] sync_flags;
  logic [N_FET-1:0]  fet_oc_s;
  logic              sense_s;
  logic              ot_trip_s;
  logic              ot_rel_s;
  logic              uv_s;

  assign raw_flags = {fet_oc, isense_hi, ot_trip, ot_release, uv_flag};

  hbs_sync #(.WIDTH(FLAG_W)) sync_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (raw_flags),
    .sync_out (sync_flags)
  );

  assign fet_oc_s  = sync_flags[FLAG_W-1:4];
  assign sense_s   = sync_flags[3];
  assign ot_trip_s = sync_flags[2];
  assign ot_rel_s  = sync_flags[1];
  assign uv_s      = sync_flags[0];

  // Current limit path: deglitch filter then persistence timer.
  logic lim_done;
  logic lim_persist_done;
  logic lim_fault;

  hbs_persist #(.LIMIT(LIM_FILT_CYC)) lim_filt_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (uv_s),
    .level (sense_s),
    .done  (lim_done)
  );

  assign ilim_req = lim_done && !uv_s;

  hbs_persist #(.LIMIT(LIM_FAULT_CYC)) lim_hold_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (uv_s),
    .level (ilim_req),
    .done  (lim_persist_done)
  );

  assign lim_fault = lim_persist_done && ilim_req;

  // Per-FET overcurrent deglitch filters.
  logic [N_FET-1:0] fet_oc_done;

  for (genvar g = 0; g < N_FET; g++) begin : g_fet
    hbs_persist #(.LIMIT(OCP_FILT_CYC)) oc_filt_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (uv_s),
      .level (fet_oc_s[g]),
      .done  (fet_oc_done[g])
    );
  end

  // Latched overcurrent and thermal states.
  logic oc_latch_q;
  logic oc_latch_d;
  logic ot_state_q;
  logic ot_state_d;

  always_comb begin
    oc_latch_d = oc_latch_q | (|fet_oc_done);
    if (uv_s) oc_latch_d = 1'b0;
  end

  always_comb begin
    ot_state_d = ot_state_q;
    if (uv_s)           ot_state_d = 1'b0;
    else if (ot_trip_s) ot_state_d = 1'b1;
    else if (ot_rel_s)  ot_state_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oc_latch_q <= 1'b0;
      ot_state_q <= 1'b0;
    end else begin
      oc_latch_q <= oc_latch_d;
      ot_state_q <= ot_state_d;
    end
  end

  // Outputs.
  assign logic_rst = uv_s;
  assign bridge_en = !(oc_latch_q || ot_state_q || uv_s);
  assign fault_n   = !(lim_fault || oc_latch_q || ot_state_q || uv_s);

endmodule

// File: rtl/hbs_checker.sv
module hbs_checker (
  input logic clk,
  input logic rst_n,
  input logic bridge_en,
  input logic ilim_req,
  input logic fault_n,
  input logic logic_rst,
  input logic oc_latch_q,
  input logic sense_s
);

  AST_BRIDGE_OFF_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
    !bridge_en |-> !fault_n); // R7

  AST_UV_BLOCKS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    logic_rst |-> (!bridge_en && !ilim_req && !fault_n)); // R10

  AST_OC_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_latch_q && !logic_rst) |=> oc_latch_q); // R8

  AST_ILIM_NEEDS_SENSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ilim_req) |-> $past(sense_s)); // R3

  AST_FAULT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_n |-> (!bridge_en || ilim_req)); // R4

endmodule

bind hb_fault_supervisor hbs_checker chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .bridge_en  (bridge_en),
  .ilim_req   (ilim_req),
  .fault_n    (fault_n),
  .logic_rst  (logic_rst),
  .oc_latch_q (oc_latch_q),
  .sense_s    (sense_s)
);

// File: tb/hb_fault_supervisor_tb_top.sv
module hb_fault_supervisor_tb_top;

  localparam int unsigned N_FET = 4;
  localparam int L = 20;   // 100 ns at 200 MHz
  localparam int P = 200;  // 1 us at 200 MHz
  localparam int O = 10;   // 50 ns at 200 MHz

  logic             clk;
  logic             rst_n;
  logic             isense_hi;
  logic [N_FET-1:0] fet_oc;
  logic             ot_trip;
  logic             ot_release;
  logic             uv_flag;
  logic             bridge_en;
  logic             ilim_req;
  logic             fault_n;
  logic             logic_rst;

  typedef struct {
    string req;
    logic  be;
    logic  fn;
    logic  il;
    logic  lr;
  } exp_t;

  exp_t exp_q[$];
  int   checks;
  int   errors;
  bit   finished;

  hb_fault_supervisor #(
    .N_FET        (N_FET),
    .CLK_KHZ      (200000),
    .LIM_FILT_NS  (100),
    .LIM_FAULT_US (1),
    .OCP_FILT_NS  (50)
  ) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .isense_hi  (isense_hi),
    .fet_oc     (fet_oc),
    .ot_trip    (ot_trip),
    .ot_release (ot_release),
    .uv_flag    (uv_flag),
    .bridge_en  (bridge_en),
    .ilim_req   (ilim_req),
    .fault_n    (fault_n),
    .logic_rst  (logic_rst)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_out(string r, logic be, logic fn, logic il, logic lr);
    exp_t it;
    it.req = r; it.be = be; it.fn = fn; it.il = il; it.lr = lr;
    exp_q.push_back(it);
  endtask

  // Monitor: compares queued expectations on the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0) begin
        exp_t it;
        it = exp_q.pop_front();
        checks++;
        if ({bridge_en, fault_n, ilim_req, logic_rst} !== {it.be, it.fn, it.il, it.lr}) begin
          errors++;
          $display("FAIL %s actual be=%b fn=%b il=%b lr=%b expected be=%b fn=%b il=%b lr=%b",
                   it.req, bridge_en, fault_n, ilim_req, logic_rst,
                   it.be, it.fn, it.il, it.lr);
        end
      end
    end
  end

  // Watchdog.
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // Driver.
  initial begin
    checks = 0; errors = 0; finished = 0;
    rst_n = 1'b0; isense_hi = 1'b0; fet_oc = '0;
    ot_trip = 1'b0; ot_release = 1'b0; uv_flag = 1'b0;
    tick(4);
    rst_n = 1'b1;
    tick(2);
    expect_out("R1", 1, 1, 0, 0);

    // R11: sense held low, nothing from current path
    tick(L + P / 2);
    expect_out("R11", 1, 1, 0, 0);
    tick(P);
    expect_out("R11", 1, 1, 0, 0);

    // R2: pulse one cycle short of the filter
    isense_hi = 1'b1; tick(L - 1); isense_hi = 1'b0;
    tick(1); expect_out("R2", 1, 1, 0, 0);
    tick(L); expect_out("R2", 1, 1, 0, 0);

    // R3: held pulse, exact rise
    isense_hi = 1'b1;
    tick(L + 1); expect_out("R3", 1, 1, 0, 0);
    tick(1);     expect_out("R3", 1, 1, 1, 0);

    // R4: persistence fault with bridge still on
    tick(P - 1); expect_out("R4", 1, 1, 1, 0);
    tick(1);     expect_out("R4", 1, 0, 1, 0);

    // R5: self clearing
    isense_hi = 1'b0;
    tick(2); expect_out("R5", 1, 0, 1, 0);
    tick(1); expect_out("R5", 1, 1, 0, 0);

    // R5: persistence restart after a one-cycle break
    isense_hi = 1'b1;
    tick(L + 2); expect_out("R3", 1, 1, 1, 0);
    tick(P / 2);
    isense_hi = 1'b0; tick(1); isense_hi = 1'b1;
    tick(L + 1 + P); expect_out("R5", 1, 1, 1, 0);
    tick(1);         expect_out("R5", 1, 0, 1, 0);
    isense_hi = 1'b0;
    tick(4); expect_out("R5", 1, 1, 0, 0);

    // R6: short overcurrent glitch
    fet_oc[2] = 1'b1; tick(O - 1); fet_oc = '0;
    tick(3); expect_out("R6", 1, 1, 0, 0);
    tick(O); expect_out("R6", 1, 1, 0, 0);

    // R7: held overcurrent latches
    fet_oc[1] = 1'b1;
    tick(O + 2); expect_out("R7", 1, 1, 0, 0);
    tick(1);     expect_out("R7", 0, 0, 0, 0);
    fet_oc = '0;
    tick(20);    expect_out("R7", 0, 0, 0, 0);

    // R8: thermal activity does not release the latch
    ot_trip = 1'b1; tick(3); ot_trip = 1'b0;
    ot_release = 1'b1; tick(5); ot_release = 1'b0;
    tick(5); expect_out("R8", 0, 0, 0, 0);

    // R8 / R10: undervoltage releases the latch
    uv_flag = 1'b1;
    tick(2); expect_out("R10", 0, 0, 0, 1);
    tick(3); uv_flag = 1'b0;
    tick(1); expect_out("R10", 0, 0, 0, 1);
    tick(1); expect_out("R8", 1, 1, 0, 0);

    // R10: timers cleared by undervoltage
    isense_hi = 1'b1;
    tick(L + 2 + P / 2); expect_out("R10", 1, 1, 1, 0);
    uv_flag = 1'b1;
    tick(2); expect_out("R10", 0, 0, 0, 1);
    tick(2); uv_flag = 1'b0;
    tick(L + 1); expect_out("R10", 1, 1, 0, 0);
    tick(1);     expect_out("R10", 1, 1, 1, 0);
    tick(P - 1); expect_out("R10", 1, 1, 1, 0);
    tick(1);     expect_out("R10", 1, 0, 1, 0);
    isense_hi = 1'b0;
    tick(4); expect_out("R5", 1, 1, 0, 0);

    // R9: thermal trip waits for release flag
    ot_trip = 1'b1;
    tick(2); expect_out("R9", 1, 1, 0, 0);
    tick(1); expect_out("R9", 0, 0, 0, 0);
    ot_trip = 1'b0;
    tick(20); expect_out("R9", 0, 0, 0, 0);
    ot_release = 1'b1;
    tick(2); expect_out("R9", 0, 0, 0, 0);
    tick(1); expect_out("R9", 1, 1, 0, 0);
    ot_release = 1'b0;
    tick(3);

    // R9: release ignored while trip still high
    ot_trip = 1'b1; ot_release = 1'b1;
    tick(5); expect_out("R9", 0, 0, 0, 0);
    ot_trip = 1'b0;
    tick(2); expect_out("R9", 0, 0, 0, 0);
    tick(1); expect_out("R9", 1, 1, 0, 0);
    ot_release = 1'b0;

    tick(2);
    @(negedge clk);
    #1;
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule